// File: doc/BRIEF.md
# Control Pin Hold and Wake Event Qualifier

This block turns slow board-level control inputs into single-cycle event strobes for a power mode controller. A power-enable input feeds three independent hold timers: a short hold that qualifies a wakeup, a medium hold that qualifies a power-on, and a long hold that qualifies a power-off. A hard-reset input feeds two more timers: a long high hold that requests a hard reset, and a short low hold that qualifies release from it. Four wake inputs are captured by flops with an asynchronous set, so a pulse far shorter than a clock period still produces one strobe.

All hold durations are counted in ticks of a millisecond-rate time base. That time base is derived from a one-cycle enable pulse at a low reference rate (nominally 32.768 kHz) by a fractional accumulator. Each hold timer is a three-state machine: HOLD_IDLE (level not held), HOLD_COUNT (level held, counting ticks) and HOLD_DONE (strobe issued, waiting for release). The transitions are: IDLE to COUNT when the level becomes active; COUNT to IDLE when the level drops; COUNT to DONE on the tick that completes the hold, which is also when the strobe fires; and DONE to IDLE when the level drops. The mode controller that consumes the strobes is not part of this block.

Top module: `pin_event_qualifier`

## Requirements
- R1: While reset is asserted and in the first cycle after release, every strobe output is low.
- R2: The time base raises one internal tick in the cycle after an `lf_pulse_i` pulse whenever the accumulated sum of TICK_HZ per pulse reaches LF_HZ; LF_HZ is then subtracted, so LF_HZ pulses always give exactly TICK_HZ ticks.
- R3: `pwron_evt_o` is high for exactly one cycle after the PON_MS-th tick (PON_MS*TICK_HZ/1000 ticks) counted while the two-stage synchronized `pwr_en_i` stays high; the tick in the cycle where the synchronized level first goes high is not counted.
- R4: `pen_wake_evt_o` follows the rule of R3 with WAKE_MS on `pwr_en_i`.
- R5: `pwroff_evt_o` follows the rule of R3 with POFF_MS on `pwr_en_i`.
- R6: `hrst_evt_o` follows the rule of R3 with HRST_HI_MS on `hrst_i` held high.
- R7: `hrst_rel_evt_o` follows the rule of R3 with HRST_LO_MS on `hrst_i` held low; a low level present from reset counts as a hold.
- R8: A synchronized level that drops before a hold completes gives no strobe, and the next hold counts again from zero.
- R9: Each hold timer gives at most one strobe per continuous hold, and gives none again until its level has been released.
- R10: A high pulse on `wake_i[n]` of any width, even between two clock edges, gives one single-cycle strobe on `wake_evt_o[n]` in the cycle after the second clock edge that follows the pulse.
- R11: A `wake_i[n]` held high for many cycles gives exactly one strobe; a further strobe needs a low level and a new rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lf_pulse_i | input | 1 | One-cycle enable at the low reference rate |
| pwr_en_i | input | 1 | Asynchronous power-enable pin, active high |
| hrst_i | input | 1 | Asynchronous hard-reset pin, active high |
| wake_i | input | NUM_WAKE | Asynchronous wake pins, rising-edge sensitive |
| pwron_evt_o | output | 1 | Power-on hold qualified |
| pen_wake_evt_o | output | 1 | Wakeup hold on power-enable qualified |
| pwroff_evt_o | output | 1 | Power-off hold qualified |
| hrst_evt_o | output | 1 | Hard-reset high hold qualified |
| hrst_rel_evt_o | output | 1 | Hard-reset low hold qualified |
| wake_evt_o | output | NUM_WAKE | Per-pin wake edge strobe |

## Verification
The bench builds the block with LF_HZ=2500 and TICK_HZ=1000, so the tick pattern alternates between three and two reference pulses and exercises the fractional remainder, and with holds of 20, 4, 40, 25 and 5 ticks. These small durations bring the short, medium and long holds on one power-enable level, an interrupted hold that would complete if it were not restarted, and short and long hard-reset levels within a few hundred cycles. Wake pins are driven with pulses of one nanosecond against a ten-nanosecond clock and with long high levels, and the reference model follows every strobe output cycle by cycle.

// File: rtl/pq_pkg.sv
package pq_pkg;

    typedef enum logic [1:0] {
        HOLD_IDLE  = 2'd0,
        HOLD_COUNT = 2'd1,
        HOLD_DONE  = 2'd2
    } hold_state_e;

    // Convert a duration in milliseconds into ticks of the time base.
    function automatic int ms_to_ticks(input int ms, input int tick_hz);
        return (ms * tick_hz) / 1000;
    endfunction

endpackage

// File: rtl/pq_sync.sv
module pq_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/pq_tick_gen.sv
module pq_tick_gen #(
    parameter int LF_HZ   = 32768,
    parameter int TICK_HZ = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lf_pulse_i,
    output logic tick_o
);

    localparam int AW = $clog2(LF_HZ + TICK_HZ + 1);
    localparam logic [AW-1:0] STEP = AW'(TICK_HZ);
    localparam logic [AW-1:0] WRAP = AW'(LF_HZ);

    logic [AW-1:0] acc_q;
    logic [AW-1:0] sum;
    logic          wrap_now;

    assign sum      = acc_q + STEP;
    assign wrap_now = lf_pulse_i && (sum >= WRAP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            tick_o <= 1'b0;
        end else begin
            tick_o <= wrap_now;
            if (lf_pulse_i) acc_q <= wrap_now ? (sum - WRAP) : sum;
        end
    end

    // R2: a tick only ever follows a reference pulse
    p_tick_after_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> $past(lf_pulse_i));

    // R2: the accumulator never holds a full period
    p_acc_below_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q < WRAP);

endmodule

// File: rtl/pq_hold_timer.sv
module pq_hold_timer
    import pq_pkg::*;
#(
    parameter int TICKS      = 10,
    parameter bit LEVEL_HIGH = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic tick_i,
    output logic evt_o
);

    localparam int CW = $clog2(TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    hold_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic active;
    logic complete;

    assign active   = LEVEL_HIGH ? lvl_i : ~lvl_i;
    assign complete = (state_q == HOLD_COUNT) && active && tick_i && (cnt_q == LAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HOLD_IDLE:  state_d = active ? HOLD_COUNT : HOLD_IDLE;
            HOLD_COUNT: begin
                if (!active)      state_d = HOLD_IDLE;
                else if (complete) state_d = HOLD_DONE;
                else              state_d = HOLD_COUNT;
            end
            HOLD_DONE:  state_d = active ? HOLD_DONE : HOLD_IDLE;
            default:    state_d = HOLD_IDLE;
        endcase
    end

    // State register and hold counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HOLD_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != HOLD_COUNT || state_d != HOLD_COUNT) cnt_q <= '0;
            else if (tick_i)                                     cnt_q <= cnt_q + 1'b1;
        end
    end

    // Output strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_o <= 1'b0;
        else        evt_o <= complete;
    end

    // R9: a strobe lasts one cycle
    p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |=> !evt_o);

    // R8: a strobe is issued only while the level was still held
    p_fire_while_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> $past(active));

    // R9: after a strobe, the timer waits for release
    p_wait_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o && active) |-> (state_q == HOLD_DONE));

endmodule

// File: rtl/pq_wake_capture.sv
module pq_wake_capture #(
    parameter int NUM_PINS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    output logic [NUM_PINS-1:0] evt_o
);

    logic [NUM_PINS-1:0] cap_q;
    logic [NUM_PINS-1:0] ws1_q;
    logic [NUM_PINS-1:0] ws2_q;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        // Capture flop: set asynchronously by the pin, cleared once the
        // synchronized copy acknowledges it and the pin is low again.
        always_ff @(posedge clk or negedge rst_n or posedge pin_i[g]) begin
            if (!rst_n)          cap_q[g] <= 1'b0;
            else if (pin_i[g])   cap_q[g] <= 1'b1;
            else if (ws2_q[g])   cap_q[g] <= 1'b0;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ws1_q[g] <= 1'b0;
                ws2_q[g] <= 1'b0;
                evt_o[g] <= 1'b0;
            end else begin
                ws1_q[g] <= cap_q[g];
                ws2_q[g] <= ws1_q[g];
                evt_o[g] <= ws1_q[g] & ~ws2_q[g];
            end
        end

        // R11: one strobe per captured edge
        p_wake_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
            evt_o[g] |=> !evt_o[g]);
    end

endmodule

// File: rtl/pin_event_qualifier.sv
module pin_event_qualifier
    import pq_pkg::*;
#(
    parameter int NUM_WAKE   = 4,
    parameter int LF_HZ      = 32768,
    parameter int TICK_HZ    = 1000,
    parameter int PON_MS     = 100,
    parameter int WAKE_MS    = 10,
    parameter int POFF_MS    = 5000,
    parameter int HRST_HI_MS = 1000,
    parameter int HRST_LO_MS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lf_pulse_i,
    input  logic                pwr_en_i,
    input  logic                hrst_i,
    input  logic [NUM_WAKE-1:0] wake_i,
    output logic                pwron_evt_o,
    output logic                pen_wake_evt_o,
    output logic                pwroff_evt_o,
    output logic                hrst_evt_o,
    output logic                hrst_rel_evt_o,
    output logic [NUM_WAKE-1:0] wake_evt_o
);

    localparam int N_HOLD  = 5;
    localparam int N_PENIN = 3;   // timers 0..2 watch power-enable

    function automatic int hold_ticks(input int k);
        case (k)
            0:       return ms_to_ticks(PON_MS, TICK_HZ);
            1:       return ms_to_ticks(WAKE_MS, TICK_HZ);
            2:       return ms_to_ticks(POFF_MS, TICK_HZ);
            3:       return ms_to_ticks(HRST_HI_MS, TICK_HZ);
            default: return ms_to_ticks(HRST_LO_MS, TICK_HZ);
        endcase
    endfunction

    logic        tick;
    logic [1:0]  pins_s;
    logic        pen_s;
    logic        hrst_s;
    logic [N_HOLD-1:0] hold_evt;

    pq_sync #(.WIDTH(2), .STAGES(2)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({hrst_i, pwr_en_i}),
        .sync_o  (pins_s)
    );

    assign pen_s  = pins_s[0];
    assign hrst_s = pins_s[1];

    pq_tick_gen #(.LF_HZ(LF_HZ), .TICK_HZ(TICK_HZ)) i_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .lf_pulse_i (lf_pulse_i),
        .tick_o     (tick)
    );

    for (genvar k = 0; k < N_HOLD; k++) begin : g_hold
        pq_hold_timer #(
            .TICKS      (hold_ticks(k)),
            .LEVEL_HIGH (k != N_HOLD - 1)
        ) i_timer (
            .clk    (clk),
            .rst_n  (rst_n),
            .lvl_i  ((k < N_PENIN) ? pen_s : hrst_s),
            .tick_i (tick),
            .evt_o  (hold_evt[k])
        );
    end

    pq_wake_capture #(.NUM_PINS(NUM_WAKE)) i_wake (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (wake_i),
        .evt_o (wake_evt_o)
    );

    assign pwron_evt_o    = hold_evt[0];
    assign pen_wake_evt_o = hold_evt[1];
    assign pwroff_evt_o   = hold_evt[2];
    assign hrst_evt_o     = hold_evt[3];
    assign hrst_rel_evt_o = hold_evt[4];

    // R3: every hold strobe completes on a tick of the time base
    p_hold_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|hold_evt) |-> $past(tick));

    // R7: the release strobe only follows a low hard-reset level
    p_release_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hrst_rel_evt_o |-> !$past(hrst_s));

endmodule

// File: tb/test_pin_event_qualifier.sv
`timescale 1ns/1ps
module test_pin_event_qualifier;

    localparam int NW = 4;
    localparam int LF = 2500;
    localparam int TK = 1000;
    localparam int T_PON = 20, T_WAKE = 4, T_POFF = 40, T_HHI = 25, T_HLO = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lf_pulse_i = 1'b0;
    logic pwr_en_i = 1'b0;
    logic hrst_i = 1'b0;
    logic [NW-1:0] wake_i = '0;
    logic pwron_evt_o, pen_wake_evt_o, pwroff_evt_o, hrst_evt_o, hrst_rel_evt_o;
    logic [NW-1:0] wake_evt_o;

    always #5 clk = ~clk;

    pin_event_qualifier #(
        .NUM_WAKE(NW), .LF_HZ(LF), .TICK_HZ(TK),
        .PON_MS(T_PON), .WAKE_MS(T_WAKE), .POFF_MS(T_POFF),
        .HRST_HI_MS(T_HHI), .HRST_LO_MS(T_HLO)
    ) i_pin_event_qualifier (.*);

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // ---------------- behavioural reference model ----------------
    int  hold_len [5] = '{T_PON, T_WAKE, T_POFF, T_HHI, T_HLO};
    int  m_ticks [5];
    bit  m_first [5];
    bit  m_fired [5];
    bit  m_evt   [5];
    bit  m_p1, m_p2, m_h1, m_h2, m_tick;
    int  m_acc;
    bit [NW-1:0] m_lat, m_w1, m_w2, m_wevt;
    int  seen [5];
    int  wseen [NW];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_p1 = 0; m_p2 = 0; m_h1 = 0; m_h2 = 0; m_tick = 0; m_acc = 0;
            m_lat = '0; m_w1 = '0; m_w2 = '0; m_wevt = '0;
            for (int k = 0; k < 5; k++) begin
                m_ticks[k] = 0; m_first[k] = 1; m_fired[k] = 0; m_evt[k] = 0;
            end
        end else begin
            bit nl;
            for (int k = 0; k < 5; k++) begin
                bit act;
                act = (k < 3) ? m_p2 : m_h2;
                if (k == 4) act = !act;
                m_evt[k] = 0;
                if (!act) begin
                    m_ticks[k] = 0; m_fired[k] = 0; m_first[k] = 1;
                end else begin
                    if (!m_first[k] && m_tick) m_ticks[k]++;
                    m_first[k] = 0;
                    if (m_ticks[k] == hold_len[k] && !m_fired[k]) begin
                        m_evt[k] = 1; m_fired[k] = 1;
                    end
                end
            end
            if (lf_pulse_i && (m_acc + TK >= LF)) begin
                m_acc = m_acc + TK - LF; m_tick = 1;
            end else begin
                if (lf_pulse_i) m_acc = m_acc + TK;
                m_tick = 0;
            end
            m_p2 = m_p1; m_p1 = pwr_en_i;
            m_h2 = m_h1; m_h1 = hrst_i;
            for (int i = 0; i < NW; i++) begin
                m_wevt[i] = m_w1[i] && !m_w2[i];
                nl = wake_i[i] ? 1'b1 : (m_w2[i] ? 1'b0 : m_lat[i]);
                m_w2[i] = m_w1[i];
                m_w1[i] = m_lat[i];
                m_lat[i] = nl;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit [4:0] got;
            got = {hrst_rel_evt_o, hrst_evt_o, pwroff_evt_o, pen_wake_evt_o, pwron_evt_o};
            check(got[0] == m_evt[0], "R3,R2 pwron", got[0], m_evt[0]);
            check(got[1] == m_evt[1], "R4 pen_wake", got[1], m_evt[1]);
            check(got[2] == m_evt[2], "R5 pwroff", got[2], m_evt[2]);
            check(got[3] == m_evt[3], "R6 hrst", got[3], m_evt[3]);
            check(got[4] == m_evt[4], "R7 hrst_rel", got[4], m_evt[4]);
            check(wake_evt_o == m_wevt, "R10 wake", wake_evt_o, m_wevt);
            for (int k = 0; k < 5; k++) if (got[k]) seen[k]++;
            for (int i = 0; i < NW; i++) if (wake_evt_o[i]) wseen[i]++;
        end
    end

    // Reference pulse every second cycle
    initial begin
        forever begin
            @(negedge clk); lf_pulse_i = 1'b1;
            @(negedge clk); lf_pulse_i = 1'b0;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wake_pulse(input int i);
        @(negedge clk);
        wake_i[i] = 1'b1; m_lat[i] = 1'b1;
        #1 wake_i[i] = 1'b0;
    endtask

    // Watchdog
    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int b0, b1, b2, b3, b4;
        for (int k = 0; k < 5; k++) seen[k] = 0;
        for (int i = 0; i < NW; i++) wseen[i] = 0;
        idle(3);
        // R1: strobes low under reset
        check({pwron_evt_o, pen_wake_evt_o, pwroff_evt_o, hrst_evt_o, hrst_rel_evt_o, wake_evt_o} == '0,
              "R1 reset", 1, 0);
        rst_n = 1'b1;
        idle(1);
        check({pwron_evt_o, pen_wake_evt_o, pwroff_evt_o, hrst_evt_o, hrst_rel_evt_o, wake_evt_o} == '0,
              "R1 after reset", 1, 0);

        // R7: hard-reset low from reset
        idle(60);
        check(seen[4] == 1, "R7 low from reset", seen[4], 1);

        // R8: short power-enable hold: wakeup only
        pwr_en_i = 1'b1; idle(60); pwr_en_i = 1'b0; idle(10);
        check(seen[1] == 1, "R4 short hold wake", seen[1], 1);
        check(seen[0] == 0, "R8 short hold no pwron", seen[0], 0);

        // R8: interrupted hold restarts from zero
        pwr_en_i = 1'b1; idle(70); pwr_en_i = 1'b0; idle(2);
        pwr_en_i = 1'b1; idle(70); pwr_en_i = 1'b0; idle(10);
        check(seen[0] == 0, "R8 restart no pwron", seen[0], 0);

        // R3 R4 R5 R9: long hold gives each strobe once
        b1 = seen[1];
        pwr_en_i = 1'b1; idle(320);
        check(seen[0] == 1, "R3 long hold pwron", seen[0], 1);
        check(seen[2] == 1, "R5 long hold pwroff", seen[2], 1);
        check(seen[1] == b1 + 1, "R9 single wake per hold", seen[1], b1 + 1);
        idle(100);
        check(seen[0] == 1 && seen[2] == 1, "R9 no refire while held", seen[0] + seen[2], 2);
        pwr_en_i = 1'b0; idle(10);

        // R6: long hard-reset high, then release hold again
        b4 = seen[4];
        hrst_i = 1'b1; idle(200);
        check(seen[3] == 1, "R6 hrst high hold", seen[3], 1);
        hrst_i = 1'b0; idle(60);
        check(seen[4] == b4 + 1, "R7 release after high", seen[4], b4 + 1);

        // R8: short hard-reset high
        hrst_i = 1'b1; idle(50); hrst_i = 1'b0; idle(60);
        check(seen[3] == 1, "R8 short hrst no event", seen[3], 1);

        // R10: sub-cycle pulses on every wake pin
        for (int i = 0; i < NW; i++) begin
            wake_pulse(i); idle(12);
            check(wseen[i] == 1, "R10 narrow pulse", wseen[i], 1);
        end

        // R11: long high level gives one strobe
        b2 = wseen[2];
        @(negedge clk); wake_i[2] = 1'b1; m_lat[2] = 1'b1;
        idle(50);
        check(wseen[2] == b2 + 1, "R11 held level one strobe", wseen[2], b2 + 1);
        wake_i[2] = 1'b0; idle(12);
        check(wseen[2] == b2 + 1, "R11 release no strobe", wseen[2], b2 + 1);
        wake_pulse(2); idle(12);
        check(wseen[2] == b2 + 2, "R11 new edge strobe", wseen[2], b2 + 2);

        b0 = seen[0]; b3 = seen[3];
        idle(5);
        check(seen[0] == b0 && seen[3] == b3, "R9 quiet at end", seen[0] + seen[3], b0 + b3);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule